// File: doc/BRIEF.md
# Multi-Channel Countdown Timer

A bank of identical down-counting timers that share one register write port, one combinational read port and a common timebase strobe. Each channel counts down by one on every cycle where the `tick` input is high. Software arms a channel by writing its control word, which holds an arm bit, a repeat bit and a terminal count. Once the count is used up, the channel raises its own level interrupt. In repeat mode the channel reloads the terminal count and keeps running. In single mode it disarms itself.

The pending interrupt stays high until software writes an acknowledge bit into the channel's second word. Reading that same word returns the live count together with the pending flag. The tick source, the interrupt controller and the bus fabric all sit outside the block, so the tick is only a one-cycle strobe here.

Top module: `cdtimer`

## Requirements
- R1: After reset every channel is disarmed, every interrupt output is low, and every mapped address reads as zero.
- R2: The control word sits at channel offset +0x0. Bit 31 arms the channel, bit 30 selects repeat mode (1) or single mode (0), and bits [28:0] hold the terminal count. Reading the control word returns the last written arm bit, repeat bit and terminal count in those same positions, with the other bits zero.
- R3: A write to the control word also loads the live count with the terminal count. While armed, the live count falls by one on each tick cycle. It holds on every cycle without a tick.
- R4: A channel armed with terminal count N raises its interrupt on tick N+1. Ticks 1 to N leave the interrupt low.
- R5: In repeat mode the expiring tick reloads the live count with the terminal count and leaves the channel armed, so the interrupt recurs every N+1 ticks.
- R6: In single mode the expiring tick clears the arm bit. The live count then stays at zero whatever further ticks arrive.
- R7: The interrupt output is active-high and stays set until a write to the status word (channel offset +0x4) with bit 30 set. A status write with bit 30 clear leaves it set.
- R8: If an expiry and an acknowledge write fall in the same cycle, the interrupt stays set.
- R9: Writing zero to the control word stops the channel. No later tick changes its count or raises its interrupt.
- R10: Reading the status word returns the live count in bits [28:0] and the pending flag in bit 30, with the other bits zero.
- R11: Channels 0 to 3 sit at base offsets 0x00, 0x08, 0x50 and 0x58 and run independently. Writes to any other address change nothing, and reads from other addresses return zero.
- R12: If a control write falls in the same cycle as a tick, the written value takes effect and that tick does not count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timebase strobe, one count step per high cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write byte address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | ADDR_W | Register read byte address |
| rd_data | output | 32 | Register read data (combinational) |
| irq | output | N_TMR | Per-channel level interrupt, active high |

## Verification
Some rules are checked by assertions on every cycle:
- the count holds when there is no tick and falls by exactly one per tick;
- an interrupt rises only from a real expiry, and it persists until it is acknowledged, including when the acknowledge coincides with an expiry;
- repeat mode reloads and stays armed, and single mode disarms.

Other behaviour only the bench scenarios can show:
- the N+1 tick latency from arming to interrupt;
- the address map and the isolation between channels;
- the read-back layout of both words;
- the stop-on-zero write;
- a control write that lands on a tick cycle.

// File: rtl/cdtimer.sv
module cdtimer #(
  parameter int N_TMR  = 4,
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 29
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic [N_TMR-1:0]  irq
);

  localparam int ARM_B = 31;
  localparam int REP_B = 30;
  localparam int ACK_B = 30;
  localparam int PAD_W = 30 - CNT_W;

  function automatic logic [ADDR_W-1:0] base_of(input int i);
    return ADDR_W'((i / 2) * 'h50 + (i % 2) * 'h08);
  endfunction

  logic             arm_q  [N_TMR];
  logic             rep_q  [N_TMR];
  logic [CNT_W-1:0] term_q [N_TMR];
  logic [CNT_W-1:0] cnt_q  [N_TMR];
  logic [N_TMR-1:0] irq_q;
  logic [N_TMR-1:0] ld_wr, ack_wr, expire;

  assign irq = irq_q;

  for (genvar g = 0; g < N_TMR; g++) begin : g_ch
    assign ld_wr[g]  = wr_en && (wr_addr == base_of(g));
    assign ack_wr[g] = wr_en && (wr_addr == base_of(g) + ADDR_W'(4)) && wr_data[ACK_B];
    assign expire[g] = arm_q[g] && tick && !ld_wr[g] && (cnt_q[g] == '0);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        arm_q[g]  <= 1'b0;
        rep_q[g]  <= 1'b0;
        term_q[g] <= '0;
        cnt_q[g]  <= '0;
      end else if (ld_wr[g]) begin
        arm_q[g]  <= wr_data[ARM_B];
        rep_q[g]  <= wr_data[REP_B];
        term_q[g] <= wr_data[CNT_W-1:0];
        cnt_q[g]  <= wr_data[CNT_W-1:0];
      end else if (arm_q[g] && tick) begin
        if (cnt_q[g] == '0) begin
          if (rep_q[g]) cnt_q[g] <= term_q[g];
          else          arm_q[g] <= 1'b0;
        end else begin
          cnt_q[g] <= cnt_q[g] - 1'b1;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n)         irq_q[g] <= 1'b0;
      else if (expire[g]) irq_q[g] <= 1'b1;
      else if (ack_wr[g]) irq_q[g] <= 1'b0;
    end

    // R3: no tick, no movement
    p_hold_no_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !ld_wr[g]) |=> $stable(cnt_q[g]));
    // R3: exactly one step per tick
    p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (arm_q[g] && tick && !ld_wr[g] && cnt_q[g] != '0) |=>
      (cnt_q[g] == CNT_W'($past(cnt_q[g]) - 1'b1)));
    // R4: interrupt rises only from an expiry
    p_rise_from_expiry_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_q[g]) |-> $past(expire[g]));
    // R5: repeat mode reloads and stays armed
    p_repeat_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (expire[g] && rep_q[g]) |=> (arm_q[g] && cnt_q[g] == $past(term_q[g])));
    // R6: single mode disarms
    p_single_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (expire[g] && !rep_q[g]) |=> !arm_q[g]);
    // R7: pending holds without acknowledge
    p_irq_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_q[g] && !ack_wr[g]) |=> irq_q[g]);
    // R8: expiry beats acknowledge
    p_expiry_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      expire[g] |=> irq_q[g]);
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < N_TMR; i++) begin
      if (rd_addr == base_of(i))
        rd_data = {arm_q[i], rep_q[i], {PAD_W{1'b0}}, term_q[i]};
      else if (rd_addr == base_of(i) + ADDR_W'(4))
        rd_data = {1'b0, irq_q[i], {PAD_W{1'b0}}, cnt_q[i]};
    end
  end

endmodule

// File: tb/cdtimer_tb.sv
module cdtimer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [3:0]  irq;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  cdtimer u_dut (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq(irq));

  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_TK = 2'd2, OP_IQ = 2'd3;
  localparam int NV = 36;
  // {op, addr, data-or-expected, requirement}
  localparam logic [45:0] VEC [NV] = '{
    {OP_RD, 8'h00, 32'h0000_0000, 4'd1},   // R1
    {OP_RD, 8'h04, 32'h0000_0000, 4'd1},   // R1
    {OP_WR, 8'h00, 32'h8000_0004, 4'd2},
    {OP_RD, 8'h00, 32'h8000_0004, 4'd2},   // R2
    {OP_RD, 8'h04, 32'h0000_0004, 4'd10},  // R10
    {OP_TK, 8'h00, 32'd2,         4'd3},
    {OP_RD, 8'h04, 32'h0000_0002, 4'd3},   // R3
    {OP_IQ, 8'h00, 32'h0,         4'd4},   // R4
    {OP_TK, 8'h00, 32'd2,         4'd4},
    {OP_IQ, 8'h00, 32'h0,         4'd4},   // R4 tick N
    {OP_TK, 8'h00, 32'd1,         4'd4},
    {OP_IQ, 8'h00, 32'h1,         4'd4},   // R4 tick N+1
    {OP_RD, 8'h00, 32'h0000_0004, 4'd6},   // R6 disarmed
    {OP_RD, 8'h04, 32'h4000_0000, 4'd10},  // R10
    {OP_TK, 8'h00, 32'd3,         4'd6},
    {OP_RD, 8'h04, 32'h4000_0000, 4'd6},   // R6 stays at zero
    {OP_WR, 8'h04, 32'h0000_0000, 4'd7},
    {OP_IQ, 8'h00, 32'h1,         4'd7},   // R7 no ack bit
    {OP_WR, 8'h04, 32'h4000_0000, 4'd7},
    {OP_IQ, 8'h00, 32'h0,         4'd7},   // R7 ack
    {OP_WR, 8'h08, 32'hC000_0002, 4'd5},
    {OP_TK, 8'h00, 32'd3,         4'd5},
    {OP_IQ, 8'h00, 32'h2,         4'd5},   // R5
    {OP_RD, 8'h0C, 32'h4000_0002, 4'd5},   // R5 reloaded
    {OP_WR, 8'h0C, 32'h4000_0000, 4'd5},
    {OP_TK, 8'h00, 32'd3,         4'd5},
    {OP_IQ, 8'h00, 32'h2,         4'd5},   // R5 recurs
    {OP_RD, 8'h08, 32'hC000_0002, 4'd5},   // R5 still armed
    {OP_WR, 8'h0C, 32'h4000_0000, 4'd9},
    {OP_WR, 8'h08, 32'h0000_0000, 4'd9},
    {OP_TK, 8'h00, 32'd5,         4'd9},
    {OP_IQ, 8'h00, 32'h0,         4'd9},   // R9
    {OP_RD, 8'h0C, 32'h0000_0000, 4'd9},   // R9
    {OP_WR, 8'h58, 32'h8000_0000, 4'd11},
    {OP_WR, 8'h10, 32'hC000_0001, 4'd11},
    {OP_RD, 8'h10, 32'h0000_0000, 4'd11}   // R11 unmapped
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic tk);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; tick = tk;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(negedge clk); rd_addr = a; #1;
    chk(rd_data, exp, req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int v = 0; v < NV; v++) begin
      string tag;
      tag = $sformatf("R%0d", VEC[v][3:0]);
      case (VEC[v][45:44])
        OP_WR: wr(VEC[v][43:36], VEC[v][35:4], 1'b0);
        OP_RD: rd(VEC[v][43:36], VEC[v][35:4], tag);
        OP_TK: ticks(int'(VEC[v][35:4]));
        default: begin @(negedge clk); chk({28'h0, irq}, VEC[v][35:4], tag); end
      endcase
    end
    // R11: channel 3 alone fires after one tick
    ticks(1);
    @(negedge clk); chk({28'h0, irq}, 32'h8, "R11");
    rd(8'h50, 32'h0, "R11");
    rd(8'h58, 32'h0000_0000, "R11");
    // R8: acknowledge on an expiry cycle
    wr(8'h50, 32'hC000_0000, 1'b0);
    ticks(1);
    @(negedge clk); chk({31'h0, irq[2]}, 32'h1, "R8 pre");
    wr(8'h54, 32'h4000_0000, 1'b1);
    @(negedge clk); chk({31'h0, irq[2]}, 32'h1, "R8");
    wr(8'h54, 32'h4000_0000, 1'b0);
    @(negedge clk); chk({31'h0, irq[2]}, 32'h0, "R7");
    // R12: control write on a tick cycle
    wr(8'h50, 32'h8000_0007, 1'b1);
    rd(8'h54, 32'h0000_0007, "R12");
    // R3: idle cycles hold the count
    repeat (10) @(negedge clk);
    rd(8'h54, 32'h0000_0007, "R3");
    // R1: reset in mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk({28'h0, irq}, 32'h0, "R1");
    rd(8'h50, 32'h0, "R1");
    rd(8'h58, 32'h0, "R1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule